// File: doc/BRIEF.md
# Framer Signaling Register Access Unit

This block connects a framed TDM line stream (T1 with 24 channels, or a 32-slot CEPT frame) to a bank of processor-visible signaling registers. One set of mode controls governs both the transmit and the receive path. Frame and time-slot counters come from outside; line coding, alignment and bit positions of robbed bits are handled elsewhere.

A small mode state machine holds the active signaling mode. Its states are `MODE_ROBBED` (per-channel robbed-bit signaling, the reset state), `MODE_TRANSPARENT` (data untouched, signaling placed by the system) and `MODE_COMMON` (common-channel signaling). Its transitions happen only on a write to the control register: any state goes to `MODE_TRANSPARENT` when the transparent bit is written 1, otherwise to `MODE_COMMON` when the common-channel bit is written 1, otherwise to `MODE_ROBBED`. The transparent bit therefore takes priority.

In robbed-bit mode each channel's transmit register supplies a two-bit mode code that is presented for both the transmit and the receive copy of that channel. In common-channel mode the transmit registers are sent, one per frame, in the dedicated slot, and the same slot on receive is captured into receive registers. Register access is a plain address / write-data / write-enable / read-data bus with combinational reads.

Top module: `sig_access_unit`

## Requirements
- R1: After reset the control register, all 24 transmit registers and all 24 receive registers read 0, and the mode state is `MODE_ROBBED`.
- R2: With the transparent bit (control bit 0) set, `tx_out` equals `tx_in` in every slot, even when the common-channel bit is also set, and both robbed-bit mode outputs are 0.
- R3: `tx_mf_mark` is 1 exactly when `tx_valid` is 1 with slot 0 of frame 0, and `rx_mf_mark` likewise for the receive side, in every mode.
- R4: In `MODE_ROBBED` with T1 format (control bit 1 = 0), `tx_rb_mode` is bits [5:4] of the transmit register addressed by `tx_slot`, and `rx_rb_mode` is bits [5:4] of the transmit register addressed by `rx_slot`; `rx_data` has no effect on either.
- R5: With CEPT format (control bit 1 = 1), in `MODE_COMMON`, or for a slot 24 or above, both robbed-bit mode outputs are 0.
- R6: In `MODE_COMMON` with `tx_valid` set, slot 23 (T1) or slot 16 (CEPT) carries the whole transmit register whose index is `tx_frame`, for frame below 24 (T1) or 17 (CEPT); every other slot and frame passes `tx_in`.
- R7: In `MODE_COMMON`, a valid receive byte in slot 23 (T1) or slot 16 (CEPT) is stored at the clock edge ending that slot into the receive register indexed by `rx_frame`, for frame below 24 (T1) or 17 (CEPT); higher frames store nothing.
- R8: Address map: 0x00–0x17 transmit registers (read/write), 0x20–0x37 receive registers (read-only, writes ignored), 0x40 control; every other address reads 0.
- R9: The control register keeps bits 0 (transparent), 1 (CEPT), 2 (common-channel) and 5 (associated signaling); the other bits read 0. `assoc_active` is 1 only when bit 5 is set, bit 1 is clear and the mode is not `MODE_TRANSPARENT`.
- R10: Outside `MODE_COMMON` the receive registers never change, whatever arrives on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_valid | input | 1 | Transmit slot byte valid |
| tx_slot | input | 5 | Transmit time-slot number |
| tx_frame | input | 5 | Transmit frame number within multiframe |
| tx_in | input | 8 | Transmit byte from system |
| tx_out | output | 8 | Transmit byte to line |
| tx_rb_mode | output | 2 | Robbed-bit mode code for current transmit slot |
| tx_mf_mark | output | 1 | Transmit multiframe marker |
| rx_valid | input | 1 | Receive slot byte valid |
| rx_slot | input | 5 | Receive time-slot number |
| rx_frame | input | 5 | Receive frame number within multiframe |
| rx_data | input | 8 | Receive byte from line |
| rx_rb_mode | output | 2 | Robbed-bit mode code for current receive slot |
| rx_mf_mark | output | 1 | Receive multiframe marker |
| assoc_active | output | 1 | Associated signaling in force |

## Verification
A wrong mode state shows at once, in the same cycle, on `tx_out` of the common-channel slot and on the robbed-bit mode outputs, since these are combinational from the state and the registers. A capture into the wrong receive register, or a capture outside common-channel mode, is visible on the first read of the receive map after the offending slot ends. Control bits kept or dropped wrongly appear on the next read of address 0x40 and on `assoc_active` one cycle after the write.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;

    localparam int SLOT_W = 5;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        MODE_ROBBED      = 2'd0,
        MODE_TRANSPARENT = 2'd1,
        MODE_COMMON      = 2'd2
    } sig_mode_e;

    typedef struct packed {
        logic assoc;
        logic common;
        logic cept;
        logic transp;
    } sig_ctrl_t;

endpackage

// File: rtl/sigacc_mode_fsm.sv
module sigacc_mode_fsm
    import sigacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_we,
    input  sig_ctrl_t ctrl_wr,
    output sig_ctrl_t ctrl_q,
    output sig_mode_e mode_q,
    output logic      rb_enable,
    output logic      cc_enable,
    output logic      assoc_active
);

    sig_mode_e mode_d;
    sig_mode_e wr_target;

    always_comb begin
        if (ctrl_wr.transp)      wr_target = MODE_TRANSPARENT;
        else if (ctrl_wr.common) wr_target = MODE_COMMON;
        else                     wr_target = MODE_ROBBED;
    end

    // next-state: transitions only on a control write
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ROBBED:      if (ctrl_we) mode_d = wr_target;
            MODE_TRANSPARENT: if (ctrl_we) mode_d = wr_target;
            MODE_COMMON:      if (ctrl_we) mode_d = wr_target;
            default:          mode_d = MODE_ROBBED;
        endcase
    end

    // state register and control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ROBBED;
            ctrl_q <= '0;
        end else begin
            mode_q <= mode_d;
            if (ctrl_we) ctrl_q <= ctrl_wr;
        end
    end

    // outputs per state
    always_comb begin
        rb_enable    = 1'b0;
        cc_enable    = 1'b0;
        assoc_active = 1'b0;
        unique case (mode_q)
            MODE_ROBBED: begin
                rb_enable    = !ctrl_q.cept;
                assoc_active = ctrl_q.assoc && !ctrl_q.cept;
            end
            MODE_TRANSPARENT: begin
                rb_enable = 1'b0;
            end
            MODE_COMMON: begin
                cc_enable    = 1'b1;
                assoc_active = ctrl_q.assoc && !ctrl_q.cept;
            end
            default: begin
                rb_enable = 1'b0;
            end
        endcase
    end

    // R9
    assoc_t1_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        assoc_active |-> (!ctrl_q.cept && ctrl_q.assoc && mode_q != MODE_TRANSPARENT));

    // R2
    transp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wr.transp) |=> (mode_q == MODE_TRANSPARENT));

endmodule

// File: rtl/sigacc_tx_path.sv
module sigacc_tx_path
    import sigacc_pkg::*;
#(
    parameter int NCH        = 24,
    parameter int CEPT_REGS  = 17,
    parameter int T1_SLOT    = 23,
    parameter int CEPT_SLOT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rb_enable,
    input  logic              cc_enable,
    input  logic              cept,
    input  logic              tx_valid,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [SLOT_W-1:0] tx_frame,
    input  logic [DATA_W-1:0] tx_in,
    output logic [DATA_W-1:0] tx_out,
    output logic [1:0]        tx_rb_mode,
    output logic              tx_mf_mark,
    input  logic [SLOT_W-1:0] rx_slot,
    output logic [1:0]        rx_rb_mode
);

    localparam logic [SLOT_W-1:0] NCH_L     = SLOT_W'(NCH);
    localparam logic [SLOT_W-1:0] CEPT_LIM  = SLOT_W'(CEPT_REGS);
    localparam logic [SLOT_W-1:0] T1_CC     = SLOT_W'(T1_SLOT);
    localparam logic [SLOT_W-1:0] CEPT_CC   = SLOT_W'(CEPT_SLOT);

    logic [DATA_W-1:0] regs_q [NCH];
    logic [SLOT_W-1:0] cc_slot;
    logic [SLOT_W-1:0] cc_limit;

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_idx == SLOT_W'(i))
                regs_q[i] <= wr_data;
        end
    end

    always_comb rd_data = (rd_idx < NCH_L) ? regs_q[rd_idx] : '0;

    assign cc_slot  = cept ? CEPT_CC : T1_CC;
    assign cc_limit = cept ? CEPT_LIM : NCH_L;

    always_comb begin
        tx_out = tx_in;
        if (cc_enable && tx_valid && tx_slot == cc_slot && tx_frame < cc_limit)
            tx_out = regs_q[tx_frame];
    end

    always_comb begin
        tx_rb_mode = 2'b00;
        rx_rb_mode = 2'b00;
        if (rb_enable && tx_slot < NCH_L) tx_rb_mode = regs_q[tx_slot][5:4];
        if (rb_enable && rx_slot < NCH_L) rx_rb_mode = regs_q[rx_slot][5:4];
    end

    assign tx_mf_mark = tx_valid && tx_slot == '0 && tx_frame == '0;

    // R5
    cept_no_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cept |-> (tx_rb_mode == 2'b00 && rx_rb_mode == 2'b00));

    // R3
    tx_mark_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mf_mark |-> (tx_valid && tx_slot == '0));

    // R2
    tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_enable |-> (tx_out == tx_in));

endmodule

// File: rtl/sigacc_rx_path.sv
module sigacc_rx_path
    import sigacc_pkg::*;
#(
    parameter int NCH        = 24,
    parameter int CEPT_REGS  = 17,
    parameter int T1_SLOT    = 23,
    parameter int CEPT_SLOT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cc_enable,
    input  logic              cept,
    input  logic              rx_valid,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [SLOT_W-1:0] rx_frame,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_mf_mark
);

    localparam logic [SLOT_W-1:0] NCH_L    = SLOT_W'(NCH);
    localparam logic [SLOT_W-1:0] CEPT_LIM = SLOT_W'(CEPT_REGS);
    localparam logic [SLOT_W-1:0] T1_CC    = SLOT_W'(T1_SLOT);
    localparam logic [SLOT_W-1:0] CEPT_CC  = SLOT_W'(CEPT_SLOT);

    logic [NCH-1:0][DATA_W-1:0] regs_q;
    logic                       capture;
    logic [SLOT_W-1:0]          cap_slot;
    logic [SLOT_W-1:0]          cap_limit;

    assign cap_slot  = cept ? CEPT_CC : T1_CC;
    assign cap_limit = cept ? CEPT_LIM : NCH_L;
    assign capture   = cc_enable && rx_valid && rx_slot == cap_slot && rx_frame < cap_limit;

    // whole-byte update at the edge closing the capture slot
    for (genvar i = 0; i < NCH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (capture && rx_frame == SLOT_W'(i))
                regs_q[i] <= rx_data;
        end
    end

    always_comb rd_data = (rd_idx < NCH_L) ? regs_q[rd_idx] : '0;

    assign rx_mf_mark = rx_valid && rx_slot == '0 && rx_frame == '0;

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_enable |=> $stable(regs_q));

    // R7
    rx_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_slot != cap_slot) |=> $stable(regs_q));

    // R3
    rx_mark_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mf_mark |-> (rx_valid && rx_frame == '0));

endmodule

// File: rtl/sig_access_unit.sv
module sig_access_unit
    import sigacc_pkg::*;
#(
    parameter int NCH       = 24,
    parameter int CEPT_REGS = 17,
    parameter int T1_SLOT   = 23,
    parameter int CEPT_SLOT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    output logic [7:0]  bus_rdata,
    input  logic        tx_valid,
    input  logic [4:0]  tx_slot,
    input  logic [4:0]  tx_frame,
    input  logic [7:0]  tx_in,
    output logic [7:0]  tx_out,
    output logic [1:0]  tx_rb_mode,
    output logic        tx_mf_mark,
    input  logic        rx_valid,
    input  logic [4:0]  rx_slot,
    input  logic [4:0]  rx_frame,
    input  logic [7:0]  rx_data,
    output logic [1:0]  rx_rb_mode,
    output logic        rx_mf_mark,
    output logic        assoc_active
);

    localparam logic [1:0]        PAGE_TX   = 2'b00;
    localparam logic [1:0]        PAGE_RX   = 2'b01;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h40;

    sig_ctrl_t         ctrl_q;
    sig_ctrl_t         ctrl_wr;
    sig_mode_e         mode_q;
    logic              rb_enable;
    logic              cc_enable;
    logic              ctrl_we;
    logic              tx_wr;
    logic [DATA_W-1:0] tx_rd;
    logic [DATA_W-1:0] rx_rd;
    logic [1:0]        page;

    assign page    = bus_addr[6:5];
    assign ctrl_we = bus_we && bus_addr == CTRL_ADDR;
    assign tx_wr   = bus_we && page == PAGE_TX;
    assign ctrl_wr = '{assoc: bus_wdata[5], common: bus_wdata[2],
                       cept: bus_wdata[1], transp: bus_wdata[0]};

    sigacc_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wr      (ctrl_wr),
        .ctrl_q       (ctrl_q),
        .mode_q       (mode_q),
        .rb_enable    (rb_enable),
        .cc_enable    (cc_enable),
        .assoc_active (assoc_active)
    );

    sigacc_tx_path #(
        .NCH(NCH), .CEPT_REGS(CEPT_REGS), .T1_SLOT(T1_SLOT), .CEPT_SLOT(CEPT_SLOT)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tx_wr),
        .wr_idx     (bus_addr[4:0]),
        .wr_data    (bus_wdata),
        .rd_idx     (bus_addr[4:0]),
        .rd_data    (tx_rd),
        .rb_enable  (rb_enable),
        .cc_enable  (cc_enable),
        .cept       (ctrl_q.cept),
        .tx_valid   (tx_valid),
        .tx_slot    (tx_slot),
        .tx_frame   (tx_frame),
        .tx_in      (tx_in),
        .tx_out     (tx_out),
        .tx_rb_mode (tx_rb_mode),
        .tx_mf_mark (tx_mf_mark),
        .rx_slot    (rx_slot),
        .rx_rb_mode (rx_rb_mode)
    );

    sigacc_rx_path #(
        .NCH(NCH), .CEPT_REGS(CEPT_REGS), .T1_SLOT(T1_SLOT), .CEPT_SLOT(CEPT_SLOT)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cc_enable  (cc_enable),
        .cept       (ctrl_q.cept),
        .rx_valid   (rx_valid),
        .rx_slot    (rx_slot),
        .rx_frame   (rx_frame),
        .rx_data    (rx_data),
        .rd_idx     (bus_addr[4:0]),
        .rd_data    (rx_rd),
        .rx_mf_mark (rx_mf_mark)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (page)
            PAGE_TX: bus_rdata = tx_rd;
            PAGE_RX: bus_rdata = rx_rd;
            default: if (bus_addr == CTRL_ADDR)
                         bus_rdata = {2'b00, ctrl_q.assoc, 2'b00,
                                      ctrl_q.common, ctrl_q.cept, ctrl_q.transp};
        endcase
    end

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page[1] && bus_addr != CTRL_ADDR) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/sig_access_unit_bench.sv
module sig_access_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       tx_valid = 1'b0;
    logic [4:0] tx_slot = '0;
    logic [4:0] tx_frame = '0;
    logic [7:0] tx_in = '0;
    logic [7:0] tx_out;
    logic [1:0] tx_rb_mode;
    logic       tx_mf_mark;
    logic       rx_valid = 1'b0;
    logic [4:0] rx_slot = '0;
    logic [4:0] rx_frame = '0;
    logic [7:0] rx_data = '0;
    logic [1:0] rx_rb_mode;
    logic       rx_mf_mark;
    logic       assoc_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sig_access_unit u_sig_access_unit (.*);

    // {ctrl, slot, frame, tx_in, exp tx_out, exp rb mode}; tx reg i holds i*8'h13
    localparam int NV = 11;
    localparam logic [47:0] VEC [NV] = '{
        {8'h01, 8'd23, 8'd5,  8'h3C, 8'h3C, 8'd0},  // R2 transparent
        {8'h00, 8'd2,  8'd0,  8'h11, 8'h11, 8'd2},  // R4
        {8'h00, 8'd3,  8'd1,  8'h22, 8'h22, 8'd3},  // R4
        {8'h00, 8'd1,  8'd2,  8'h44, 8'h44, 8'd1},  // R4
        {8'h04, 8'd23, 8'd5,  8'h77, 8'h5F, 8'd0},  // R6
        {8'h04, 8'd23, 8'd23, 8'h77, 8'hB5, 8'd0},  // R6
        {8'h04, 8'd10, 8'd5,  8'h66, 8'h66, 8'd0},  // R6 other slot
        {8'h06, 8'd16, 8'd3,  8'h55, 8'h39, 8'd0},  // R6 CEPT
        {8'h06, 8'd16, 8'd20, 8'h12, 8'h12, 8'd0},  // R6 CEPT frame out of range
        {8'h02, 8'd2,  8'd0,  8'h21, 8'h21, 8'd0},  // R5 CEPT robbed
        {8'h05, 8'd23, 8'd5,  8'h9A, 8'h9A, 8'd0}   // R2 priority
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rx_byte(input logic [4:0] s, input logic [4:0] f, input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_slot = s; rx_frame = f; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_slot = 5'd0; rx_frame = 5'd0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(7'h40, rd); chk("R1 ctrl", rd, 8'h00);
        bus_rd(7'h05, rd); chk("R1 tx reg", rd, 8'h00);
        bus_rd(7'h37, rd); chk("R1 rx reg", rd, 8'h00);
        #1 chk("R1 mode", {6'd0, tx_rb_mode}, 8'h00);

        for (int i = 0; i < 24; i++) bus_wr(7'(i), 8'(i * 8'h13));
        bus_rd(7'h17, rd); chk("R8 tx readback", rd, 8'hB5);

        for (int v = 0; v < NV; v++) begin
            bus_wr(7'h40, VEC[v][47:40]);
            @(negedge clk);
            tx_valid = 1'b1; tx_slot = VEC[v][36:32]; tx_frame = VEC[v][28:24];
            tx_in = VEC[v][23:16];
            rx_slot = VEC[v][36:32]; rx_frame = VEC[v][28:24]; rx_data = 8'hFF;
            #1;
            chk("R2/R6 tx_out", tx_out, VEC[v][15:8]);
            chk("R4/R5 tx_rb_mode", {6'd0, tx_rb_mode}, VEC[v][7:0]);
            chk("R4 rx_rb_mode", {6'd0, rx_rb_mode}, VEC[v][7:0]);
            @(negedge clk);
            tx_valid = 1'b0; rx_slot = 5'd0; rx_frame = 5'd0; rx_data = 8'h00;
        end

        // R5 slot beyond channel count
        bus_wr(7'h40, 8'h00);
        @(negedge clk); tx_slot = 5'd27; #1 chk("R5 slot 27", {6'd0, tx_rb_mode}, 8'h00);

        // R3 markers
        @(negedge clk); tx_valid = 1'b1; tx_slot = 5'd0; tx_frame = 5'd0;
        rx_valid = 1'b0; rx_slot = 5'd0; rx_frame = 5'd0;
        #1 chk("R3 tx mark", {7'd0, tx_mf_mark}, 8'h01);
        chk("R3 rx mark no valid", {7'd0, rx_mf_mark}, 8'h00);
        @(negedge clk); tx_slot = 5'd1; #1 chk("R3 tx mark slot1", {7'd0, tx_mf_mark}, 8'h00);
        tx_valid = 1'b0;
        bus_wr(7'h40, 8'h01);
        @(negedge clk); rx_valid = 1'b1; rx_slot = 5'd0; rx_frame = 5'd0;
        #1 chk("R3 rx mark transparent", {7'd0, rx_mf_mark}, 8'h01);
        @(negedge clk); rx_frame = 5'd1; #1 chk("R3 rx mark frame1", {7'd0, rx_mf_mark}, 8'h00);
        rx_valid = 1'b0;

        // R10 no capture in transparent / robbed
        rx_byte(5'd23, 5'd4, 8'hAA);
        bus_rd(7'h24, rd); chk("R10 transparent", rd, 8'h00);

        // R7 T1 capture
        bus_wr(7'h40, 8'h04);
        rx_byte(5'd23, 5'd4, 8'hC3);
        bus_rd(7'h24, rd); chk("R7 T1 capture", rd, 8'hC3);
        rx_byte(5'd16, 5'd6, 8'h77);
        bus_rd(7'h26, rd); chk("R7 T1 slot16 ignored", rd, 8'h00);

        // R7 CEPT capture and limit
        bus_wr(7'h40, 8'h06);
        rx_byte(5'd16, 5'd16, 8'h5A);
        bus_rd(7'h30, rd); chk("R7 CEPT frame16", rd, 8'h5A);
        rx_byte(5'd16, 5'd17, 8'hEE);
        bus_rd(7'h31, rd); chk("R7 CEPT frame17", rd, 8'h00);
        bus_rd(7'h30, rd); chk("R7 CEPT frame16 kept", rd, 8'h5A);

        // R10 robbed mode
        bus_wr(7'h40, 8'h00);
        rx_byte(5'd23, 5'd4, 8'h99);
        bus_rd(7'h24, rd); chk("R10 robbed", rd, 8'hC3);

        // R8 write to rx page ignored, unmapped reads 0
        bus_wr(7'h24, 8'h11);
        bus_rd(7'h24, rd); chk("R8 rx write ignored", rd, 8'hC3);
        bus_rd(7'h41, rd); chk("R8 unmapped", rd, 8'h00);
        bus_rd(7'h1A, rd); chk("R8 tx hole", rd, 8'h00);

        // R9 control bits and assoc flag
        bus_wr(7'h40, 8'hFF);
        bus_rd(7'h40, rd); chk("R9 ctrl mask", rd, 8'h27);
        bus_wr(7'h40, 8'h20); #1 chk("R9 assoc T1", {7'd0, assoc_active}, 8'h01);
        bus_wr(7'h40, 8'h24); #1 chk("R9 assoc common", {7'd0, assoc_active}, 8'h01);
        bus_wr(7'h40, 8'h22); #1 chk("R9 assoc CEPT", {7'd0, assoc_active}, 8'h00);
        bus_wr(7'h40, 8'h21); #1 chk("R9 assoc transparent", {7'd0, assoc_active}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule